// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the control side of a small core's flash self-programming path. Software writes an 8-bit control/status register through a simple write port. The core reports each program-memory store instruction and each program-memory load instruction, together with its Z-pointer. From the bits armed in the register and the instruction that follows, the block decides which command runs: page erase, page write, page-buffer fill or lock/fuse read.

For a page operation, the block gives a start pulse and the page number to the flash array. It holds the CPU in halt until the array returns done. A page-buffer fill is passed on as a strobe that carries the R1:R0 data word and the in-page offset. A lock/fuse read replaces the load result with the lock byte or the fuse byte. The block also clears the temporary page buffer when software asks for it, and requests the ready interrupt. Each command bit is armed only for a short window after the write. It clears itself when the operation ends or when the window runs out.

The sequencer has six states, with these transitions:
- `S_IDLE` goes to `S_ARM_PG`, `S_ARM_FILL` or `S_ARM_LOCK` on an arming write.
- Each armed state goes back to `S_IDLE` when its window expires, or on a write that arms nothing.
- An armed state takes a new arming write and restarts its window.
- `S_ARM_FILL` goes to `S_IDLE` on a store instruction, which is a fill.
- `S_ARM_LOCK` goes to `S_IDLE` on a load instruction, which is a lock/fuse read.
- `S_ARM_PG` goes to `S_ISSUE` on a store instruction.
- `S_ISSUE` always goes to `S_BUSY` after one cycle.
- `S_BUSY` goes to `S_IDLE` when the array reports done.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset every register bit reads 0. Read-back bits 6 and 5 are always 0, and no start, halt, strobe or interrupt output is active.
- R2: Arming writes are decoded on bits 3:0 (lock-set=3, page-write=2, page-erase=1, enable=0). 0x03 arms erase, 0x05 arms write, 0x09 arms lock read and 0x01 arms fill. The armed bits read back as written. Any other combination arms nothing, for example several command bits at once, or a command bit without enable.
- R3: A store instruction in any of the four cycles after an erase/write arming write gives a one-cycle `flash_start` in the next cycle. In that cycle `flash_wr` is 0 for erase and 1 for write, and `flash_page` is Z[15:7]. R1:R0 does not affect the command.
- R4: `cpu_halt` is high from the `flash_start` cycle through the cycle in which `flash_done` is sampled. In the next cycle it is low and bits 2:0 read 0.
- R5: If no store instruction arrives within four cycles of arming, bits 3:0 clear. A later store instruction then produces no start, no fill and no halt.
- R6: After arming 0x09, a load instruction within three cycles drives `lpm_ovr` high in the same cycle. `lpm_data` is then the lock byte when Z[0]=0 and the fuse byte when Z[0]=1, and the bits clear in the next cycle. A load in the fourth cycle is not overridden.
- R7: After arming 0x01, a store instruction within four cycles raises `fill_strobe` in the same cycle, with `fill_data`=R1:R0 and `fill_off`=Z[6:0]. Bit 0 reads 0 afterwards.
- R8: A write with bit 4 set gives a one-cycle `buf_clear` in the next cycle, but only if a fill has happened since the last clear or completed page write. Bit 4 always reads 0.
- R9: `irq_req` is a register. It is high one cycle after interrupt-enable (bit 7), `gie` high, enable (bit 0) low and `ee_busy` low all hold together. It is low one cycle after any of them fails.
- R10: Writes during `S_ISSUE`/`S_BUSY` update only bit 7. The armed page command keeps reading back until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read-back |
| spm_exec | input | 1 | Store-program-memory instruction executes this cycle |
| lpm_exec | input | 1 | Load-program-memory instruction executes this cycle |
| zptr | input | 16 | Z-pointer value |
| r1r0 | input | 16 | R1:R0 data word |
| gie | input | 1 | Global interrupt flag |
| ee_busy | input | 1 | EEPROM write in progress |
| lock_bits | input | 8 | Lock byte returned by a lock read |
| fuse_bits | input | 8 | Fuse byte returned by a fuse read |
| flash_done | input | 1 | Flash array finished the page operation |
| flash_start | output | 1 | One-cycle start of a page operation |
| flash_wr | output | 1 | Page operation kind: 1 write, 0 erase |
| flash_page | output | 9 | Page number for the operation |
| cpu_halt | output | 1 | CPU halt during a page operation |
| fill_strobe | output | 1 | Page-buffer word write |
| fill_data | output | 16 | Word for the page buffer |
| fill_off | output | 7 | Byte offset inside the page |
| buf_clear | output | 1 | Clear the temporary page buffer |
| lpm_ovr | output | 1 | Load result replaced by the lock or fuse byte |
| lpm_data | output | 8 | Lock or fuse byte |
| irq_req | output | 1 | Ready interrupt request |

## Verification
The results fall due at three different times:
- **Same cycle:** read-back, `fill_strobe` and `lpm_ovr`/`lpm_data` are combinational from the state and the current instruction inputs. The bench drives the instruction on a falling edge and samples these a nanosecond later, in the same cycle.
- **One cycle later:** `flash_start`, `buf_clear` and `irq_req` each lie one register behind their cause. The bench samples them on the falling edge after the rising edge that captured the cause. For the interrupt, it first confirms the output is still at its old value one cycle before.
- **Window edges:** the bench places the instruction exactly N cycles after the arming write. For each window it uses both the last accepted cycle and the first rejected cycle.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int unsigned CSR_W   = 8;
    localparam int unsigned B_IE    = 7;
    localparam int unsigned B_SRE   = 4;
    localparam int unsigned B_LOCK  = 3;
    localparam int unsigned B_PGW   = 2;
    localparam int unsigned B_PGE   = 1;
    localparam int unsigned B_EN    = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM_PG,
        S_ARM_FILL,
        S_ARM_LOCK,
        S_ISSUE,
        S_BUSY
    } spc_state_t;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_ERASE,
        REQ_WRITE,
        REQ_LOCK,
        REQ_FILL
    } spc_req_t;

    // Only an exact pattern on the command nibble arms anything.
    function automatic spc_req_t decode_req(input logic [CSR_W-1:0] wd);
        logic [3:0] nib;
        nib = {wd[B_LOCK], wd[B_PGW], wd[B_PGE], wd[B_EN]};
        unique case (nib)
            4'b0011: decode_req = REQ_ERASE;
            4'b0101: decode_req = REQ_WRITE;
            4'b1001: decode_req = REQ_LOCK;
            4'b0001: decode_req = REQ_FILL;
            default: decode_req = REQ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spc_seq.sv
module spc_seq
    import spc_pkg::*;
#(
    parameter int unsigned WIN_PAGE = 4,
    parameter int unsigned WIN_LOCK = 3,
    parameter int unsigned ZW       = 16,
    parameter int unsigned PAGE_LSB = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  spc_req_t               req,
    input  logic                   spm_exec,
    input  logic                   lpm_exec,
    input  logic [ZW-1:0]          zptr,
    input  logic                   flash_done,
    output spc_state_t             st,
    output logic                   op_wr,
    output logic [ZW-PAGE_LSB-1:0] page,
    output logic                   flash_start,
    output logic                   cpu_halt,
    output logic                   fill_hit,
    output logic                   lpm_hit,
    output logic                   op_done
);

    localparam int unsigned WIN_MAX = (WIN_PAGE > WIN_LOCK) ? WIN_PAGE : WIN_LOCK;
    localparam int unsigned CW      = $clog2(WIN_MAX + 1);
    localparam int unsigned PW      = ZW - PAGE_LSB;

    spc_state_t     st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           wr_n;
    logic [PW-1:0]  page_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            op_wr <= 1'b0;
            page  <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            op_wr <= wr_n;
            page  <= page_n;
        end
    end

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        wr_n   = op_wr;
        page_n = page;
        unique case (st)
            S_ISSUE: st_n = S_BUSY;
            S_BUSY:  if (flash_done) st_n = S_IDLE;
            default: begin
                if (st == S_ARM_PG && spm_exec) begin
                    st_n   = S_ISSUE;
                    page_n = zptr[ZW-1:PAGE_LSB];
                end else if ((st == S_ARM_FILL && spm_exec) ||
                             (st == S_ARM_LOCK && lpm_exec)) begin
                    st_n = S_IDLE;
                end else if (wr_stb) begin
                    unique case (req)
                        REQ_ERASE: begin st_n = S_ARM_PG;   wr_n = 1'b0; cnt_n = CW'(WIN_PAGE); end
                        REQ_WRITE: begin st_n = S_ARM_PG;   wr_n = 1'b1; cnt_n = CW'(WIN_PAGE); end
                        REQ_LOCK:  begin st_n = S_ARM_LOCK; cnt_n = CW'(WIN_LOCK); end
                        REQ_FILL:  begin st_n = S_ARM_FILL; cnt_n = CW'(WIN_PAGE); end
                        default:   st_n = S_IDLE;
                    endcase
                end else if (st != S_IDLE) begin
                    if (cnt == CW'(1)) st_n = S_IDLE;
                    else               cnt_n = cnt - CW'(1);
                end
            end
        endcase
    end

    always_comb begin
        flash_start = (st == S_ISSUE);
        cpu_halt    = (st == S_ISSUE) || (st == S_BUSY);
        fill_hit    = (st == S_ARM_FILL) && spm_exec;
        lpm_hit     = (st == S_ARM_LOCK) && lpm_exec;
        op_done     = (st == S_BUSY) && flash_done;
    end

    // R5: an armed page command with its last window cycle unused is dropped
    a_r5_window_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARM_PG && cnt == CW'(1) && !spm_exec && !wr_stb) |=> (st == S_IDLE));

    // R6: a lock/fuse read consumes the armed bits
    a_r6_lock_once: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_hit |=> (st == S_IDLE));

    // R4: completion leaves the busy state
    a_r4_done_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !cpu_halt);

endmodule

// File: rtl/spc_irq.sv
module spc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ie,
    input  logic gie,
    input  logic en,
    input  logic ee_busy,
    output logic irq_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= ie && gie && !en && !ee_busy;
    end

    // R9: no request while an EEPROM write or a self-programming sequence is active
    a_r9_quiet_ee: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |=> !irq_req);
    a_r9_quiet_en: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !irq_req);

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import spc_pkg::*;
#(
    parameter int unsigned ZW       = 16,
    parameter int unsigned PAGE_LSB = 7,
    parameter int unsigned DW       = 16,
    parameter int unsigned WIN_PAGE = 4,
    parameter int unsigned WIN_LOCK = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csr_we,
    input  logic [7:0]             csr_wdata,
    output logic [7:0]             csr_rdata,
    input  logic                   spm_exec,
    input  logic                   lpm_exec,
    input  logic [ZW-1:0]          zptr,
    input  logic [DW-1:0]          r1r0,
    input  logic                   gie,
    input  logic                   ee_busy,
    input  logic [7:0]             lock_bits,
    input  logic [7:0]             fuse_bits,
    input  logic                   flash_done,
    output logic                   flash_start,
    output logic                   flash_wr,
    output logic [ZW-PAGE_LSB-1:0] flash_page,
    output logic                   cpu_halt,
    output logic                   fill_strobe,
    output logic [DW-1:0]          fill_data,
    output logic [PAGE_LSB-1:0]    fill_off,
    output logic                   buf_clear,
    output logic                   lpm_ovr,
    output logic [7:0]             lpm_data,
    output logic                   irq_req
);

    spc_state_t st;
    spc_req_t   req;
    logic       ie_q;
    logic       fill_pend;
    logic       op_done;
    logic       lpm_hit;
    logic       en_bit, pge_bit, pgw_bit, lock_bit, pg_active;
    logic       clr_req;

    assign req     = decode_req(csr_wdata);
    assign clr_req = csr_we && csr_wdata[B_SRE] && fill_pend;

    spc_seq #(
        .WIN_PAGE (WIN_PAGE),
        .WIN_LOCK (WIN_LOCK),
        .ZW       (ZW),
        .PAGE_LSB (PAGE_LSB)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (csr_we),
        .req         (req),
        .spm_exec    (spm_exec),
        .lpm_exec    (lpm_exec),
        .zptr        (zptr),
        .flash_done  (flash_done),
        .st          (st),
        .op_wr       (flash_wr),
        .page        (flash_page),
        .flash_start (flash_start),
        .cpu_halt    (cpu_halt),
        .fill_hit    (fill_strobe),
        .lpm_hit     (lpm_hit),
        .op_done     (op_done)
    );

    spc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie      (ie_q),
        .gie     (gie),
        .en      (en_bit),
        .ee_busy (ee_busy),
        .irq_req (irq_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            fill_pend <= 1'b0;
            buf_clear <= 1'b0;
        end else begin
            if (csr_we) ie_q <= csr_wdata[B_IE];
            buf_clear <= clr_req;
            if (clr_req || (op_done && flash_wr)) fill_pend <= 1'b0;
            else if (fill_strobe)                 fill_pend <= 1'b1;
        end
    end

    always_comb begin
        pg_active = (st == S_ARM_PG) || (st == S_ISSUE) || (st == S_BUSY);
        en_bit    = (st != S_IDLE);
        pge_bit   = pg_active && !flash_wr;
        pgw_bit   = pg_active && flash_wr;
        lock_bit  = (st == S_ARM_LOCK);
        csr_rdata = {ie_q, 3'b000, lock_bit, pgw_bit, pge_bit, en_bit};
        fill_data = r1r0;
        fill_off  = zptr[PAGE_LSB-1:0];
        lpm_ovr   = lpm_hit;
        lpm_data  = zptr[0] ? fuse_bits : lock_bits;
    end

    // R3: start is a single pulse followed by halt
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flash_start |=> (cpu_halt && !flash_start));

    // R4: halt is released right after done is seen in the busy phase
    a_r4_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && flash_done && !flash_start) |=> !cpu_halt);

    // R8: buffer clear lasts one cycle
    a_r8_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |=> !buf_clear);

    // R7: a fill consumes the enable bit
    a_r7_fill_once: assert property (@(posedge clk) disable iff (!rst_n)
        fill_strobe |=> !csr_rdata[B_EN]);

endmodule

// File: tb/sim_selfprog_ctrl.sv
`timescale 1ns/1ps
module sim_selfprog_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = 8'h00;
    logic [7:0]  csr_rdata;
    logic        spm_exec = 1'b0;
    logic        lpm_exec = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic [15:0] r1r0 = 16'h0000;
    logic        gie = 1'b0;
    logic        ee_busy = 1'b0;
    logic [7:0]  lock_bits = 8'hC3;
    logic [7:0]  fuse_bits = 8'h5A;
    logic        flash_done = 1'b0;
    logic        flash_start, flash_wr, cpu_halt, fill_strobe, buf_clear, lpm_ovr, irq_req;
    logic [8:0]  flash_page;
    logic [15:0] fill_data;
    logic [6:0]  fill_off;
    logic [7:0]  lpm_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    selfprog_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .spm_exec(spm_exec), .lpm_exec(lpm_exec),
        .zptr(zptr), .r1r0(r1r0), .gie(gie), .ee_busy(ee_busy),
        .lock_bits(lock_bits), .fuse_bits(fuse_bits), .flash_done(flash_done),
        .flash_start(flash_start), .flash_wr(flash_wr), .flash_page(flash_page),
        .cpu_halt(cpu_halt), .fill_strobe(fill_strobe), .fill_data(fill_data),
        .fill_off(fill_off), .buf_clear(buf_clear), .lpm_ovr(lpm_ovr),
        .lpm_data(lpm_data), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [7:0]  wd;
        logic [7:0]  rd;
        logic [2:0]  gap;
        logic [15:0] z;
        logic [15:0] d;
        logic [3:0]  lat;
        logic        st;
        logic        wr;
        logic        fl;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'h03, 8'h03, 3'd1, 16'h1A80, 16'hBEEF, 4'd3, 1'b1, 1'b0, 1'b0},
        '{8'h05, 8'h05, 3'd4, 16'hFF00, 16'h0F0F, 4'd1, 1'b1, 1'b1, 1'b0},
        '{8'h03, 8'h03, 3'd5, 16'h2000, 16'h0000, 4'd1, 1'b0, 1'b0, 1'b0},
        '{8'h01, 8'h01, 3'd2, 16'h0013, 16'h1234, 4'd1, 1'b0, 1'b0, 1'b1},
        '{8'h01, 8'h01, 3'd5, 16'h0044, 16'h5555, 4'd1, 1'b0, 1'b0, 1'b0},
        '{8'h07, 8'h00, 3'd1, 16'h4000, 16'h0000, 4'd1, 1'b0, 1'b0, 1'b0},
        '{8'h02, 8'h00, 3'd1, 16'h4000, 16'h0000, 4'd1, 1'b0, 1'b0, 1'b0},
        '{8'h05, 8'h05, 3'd3, 16'h0380, 16'hAAAA, 4'd6, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic csr_write(input logic [7:0] v);
        csr_we    = 1'b1;
        csr_wdata = v;
        tick();
        csr_we    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rdata", csr_rdata, 8'h00);
        chk("R1 halt", cpu_halt, 1'b0);
        chk("R1 start", flash_start, 1'b0);
        chk("R1 irq", irq_req, 1'b0);
        chk("R1 fill", fill_strobe, 1'b0);

        // vector walk: R2, R3, R4, R5, R7
        for (int i = 0; i < NV; i++) begin
            csr_write(VEC[i].wd);
            chk("R2 readback", csr_rdata, VEC[i].rd);
            chk("R1 bits 6:5", csr_rdata[6:5], 2'b00);
            repeat (int'(VEC[i].gap) - 1) tick();
            spm_exec = 1'b1;
            zptr     = VEC[i].z;
            r1r0     = VEC[i].d;
            #1;
            chk("R7 fill strobe", fill_strobe, VEC[i].fl);
            if (VEC[i].fl) begin
                chk("R7 fill data", fill_data, VEC[i].d);
                chk("R7 fill offset", fill_off, VEC[i].z[6:0]);
            end
            tick();
            spm_exec = 1'b0;
            if (VEC[i].st) begin
                chk("R3 start", flash_start, 1'b1);
                chk("R3 kind", flash_wr, VEC[i].wr);
                chk("R3 page", flash_page, VEC[i].z[15:7]);
                chk("R4 halt at start", cpu_halt, 1'b1);
                for (int k = 0; k < int'(VEC[i].lat); k++) begin
                    tick();
                    chk("R4 halt busy", cpu_halt, 1'b1);
                    chk("R3 single start", flash_start, 1'b0);
                end
                flash_done = 1'b1;
                tick();
                flash_done = 1'b0;
                chk("R4 halt released", cpu_halt, 1'b0);
                chk("R4 auto clear", csr_rdata[2:0], 3'b000);
            end else begin
                chk("R5 no start", flash_start, 1'b0);
                chk("R5 no halt", cpu_halt, 1'b0);
                chk("R5 bits clear", csr_rdata[3:0], 4'h0);
            end
            tick();
        end

        // R6 lock read at cycle 2, Z0=0
        csr_write(8'h09);
        chk("R6 readback", csr_rdata, 8'h09);
        tick();
        lpm_exec = 1'b1; zptr = 16'h0000; #1;
        chk("R6 override lock", lpm_ovr, 1'b1);
        chk("R6 lock byte", lpm_data, 8'hC3);
        tick();
        lpm_exec = 1'b0;
        chk("R6 bits clear", csr_rdata, 8'h00);
        // R6 fuse read at cycle 3, Z0=1
        csr_write(8'h09);
        tick(); tick();
        lpm_exec = 1'b1; zptr = 16'h0001; #1;
        chk("R6 override fuse", lpm_ovr, 1'b1);
        chk("R6 fuse byte", lpm_data, 8'h5A);
        tick();
        lpm_exec = 1'b0;
        // R6 expiry: load at cycle 4
        csr_write(8'h09);
        repeat (3) tick();
        lpm_exec = 1'b1; #1;
        chk("R6 late load", lpm_ovr, 1'b0);
        tick();
        lpm_exec = 1'b0;

        // R10 write during busy keeps command
        csr_write(8'h03);
        spm_exec = 1'b1; zptr = 16'h0100;
        tick();
        spm_exec = 1'b0;
        tick();
        csr_write(8'h80);
        chk("R10 busy write", csr_rdata, 8'h83);
        flash_done = 1'b1;
        tick();
        flash_done = 1'b0;
        chk("R10 after done", csr_rdata, 8'h80);
        csr_write(8'h00);

        // R8 buffer clear
        csr_write(8'h01);
        spm_exec = 1'b1; tick(); spm_exec = 1'b0;
        csr_write(8'h10);
        chk("R8 clear pulse", buf_clear, 1'b1);
        chk("R8 bit4 reads 0", csr_rdata[4], 1'b0);
        tick();
        chk("R8 clear single", buf_clear, 1'b0);
        csr_write(8'h10);
        chk("R8 no pending fill", buf_clear, 1'b0);

        // R9 interrupt
        gie = 1'b1;
        csr_write(8'h80);
        chk("R9 irq not yet", irq_req, 1'b0);
        tick();
        chk("R9 irq set", irq_req, 1'b1);
        ee_busy = 1'b1; tick();
        chk("R9 ee busy blocks", irq_req, 1'b0);
        ee_busy = 1'b0; tick();
        chk("R9 irq again", irq_req, 1'b1);
        csr_write(8'h81);
        tick();
        chk("R9 enable blocks", irq_req, 1'b0);
        repeat (5) tick();
        chk("R9 after expiry", irq_req, 1'b1);
        csr_write(8'h00);
        gie = 1'b0;
        tick();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule